// File: doc/BRIEF.md
# Framed Signalling Slot Transmitter

The block sends low-rate signalling messages through a time-division switch. The host pushes message bytes into a 32-entry byte queue. A set of configuration pins selects how many serial bits go out per frame (1, 2 or 8), the framing style, start/stop framing, even parity and the bit order. A one-cycle arm pulse enables sending. On every frame tick the block produces one slot value that the switching fabric can copy into any number of output channels.

There are two framing styles. Message framing wraps a whole run of bytes in a single start bit and a single stop bit, with an optional parity bit before the stop bit. Byte framing either sends the data bits bare or gives every byte its own start, optional parity and stop bits. Any positions of the last frame that carry no message bits are driven to the stop level, so the line idles high.

The byte input is a valid/ready stream. A byte is accepted on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while the queue is full. A byte offered while `wr_ready` is low is discarded rather than held, and the discard is recorded. The sender must therefore respect `wr_ready` or accept the loss. Frame ticks must be at least two clock cycles apart, so that the framer has one free cycle between ticks to refill its bit queue.

Top module: `dch_slot_tx`

## Requirements
- R1: The queue holds 32 bytes and `wr_ready` is low while it is full. A byte offered while full is discarded and sets the sticky `ovf` flag. A pulse on `ovf_clr` clears the flag. The bytes already queued go out unchanged.
- R2: No serial bit leaves the block until the arm pulse has been given and a byte is in the queue. Until then every slot is 8'hFF.
- R3: `cfg_rate` selects the bits per frame: 0 gives 1 bit, 1 gives 2 bits, and 2 or 3 give 8 bits. The earliest bit of a frame is placed in slot bit 0 and later bits go to higher positions. Slot positions beyond the bit count are 1.
- R4: When `cfg_byte_mode` is 0 (message framing), a start bit (0) precedes the first data bit and a stop bit (1) follows the whole message. `cfg_frame_en` has no effect in this mode.
- R5: In message framing with `cfg_parity_en` = 1, an even parity bit computed over all data bits of the message goes between the last data bit and the stop bit.
- R6: A message ends when the queue is empty and fewer than one frame's worth of bits remain to be sent. Parity (if enabled) and the stop bit are then sent, and `tx_armed` drops to 0.
- R7: In byte framing with `cfg_frame_en` = 0, only data bits are sent, whatever the value of `cfg_parity_en`.
- R8: In byte framing with `cfg_frame_en` = 1, each byte is sent as: start 0, eight data bits, even parity of that byte (only if `cfg_parity_en` = 1), stop 1. In byte framing `tx_armed` stays set.
- R9: With `cfg_msb_first` = 0 the data bits go out from bit 0 upward. With 1 they go out from bit 7 downward.
- R10: Slot positions left over after the last bit are filled with 1. After reset the slot is 8'hFF, `tx_armed` and `ovf` are 0 and `wr_ready` is 1.
- R11: `slot_out` takes its new value on the clock edge that samples `frame_tick` high and holds it until the next tick. Ticks are at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte offered on `wr_data` |
| wr_ready | output | 1 | Queue can accept a byte |
| wr_data | input | 8 | Message byte |
| start_set | input | 1 | One-cycle pulse that arms transmission |
| tx_armed | output | 1 | Transmission is armed |
| ovf_clr | input | 1 | Clears the discard flag |
| ovf | output | 1 | Sticky flag: a byte was discarded |
| cfg_rate | input | 2 | Bits per frame select |
| cfg_byte_mode | input | 1 | 0 message framing, 1 byte framing |
| cfg_frame_en | input | 1 | Start/stop framing enable for byte framing |
| cfg_parity_en | input | 1 | Even parity enable |
| cfg_msb_first | input | 1 | Data bit order |
| frame_tick | input | 1 | One-cycle pulse, once per frame |
| slot_out | output | 8 | Slot value for the current frame |

## Verification
`wr_ready` and `ovf` respond on the edge after the write that fills the queue or is discarded. The bench therefore reads them at the falling edge that follows that write. `slot_out` changes on the edge that samples a tick. The bench raises `frame_tick` at one falling edge, lowers it at the next, reads the slot right there, and then waits two more cycles so that the framer has a free cycle before the next tick. After the last write of a test, four cycles pass before the first tick, which gives the framer time to load at least a full frame of bits.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  localparam int DTX_DATA_W     = 8;
  localparam int DTX_FIFO_DEPTH = 32;
  localparam int DTX_QUEUE_W    = 24;

  // rate code to bits per frame; codes above 1 use the whole slot
  function automatic int frame_bits(logic [1:0] rate, int slot_w);
    case (rate)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return slot_w;
    endcase
  endfunction
endpackage

// File: rtl/dtx_fifo.sv
module dtx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         rd_pop,
  output logic [W-1:0] rd_data,
  output logic         empty,
  input  logic         ovf_clr,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          full, push, pop;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == (AW+1)'(DEPTH));
  assign empty    = (count == '0);
  assign wr_ready = !full;
  assign push     = wr_valid && !full;
  assign pop      = rd_pop && !empty;
  assign rd_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_valid && full) ovf <= 1'b1;
      else if (ovf_clr)     ovf <= 1'b0;
    end
  end

  // R1: a refused byte is recorded
  assert_ovf_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> ovf);
  // R1: the flag holds until cleared
  assert_ovf_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/dtx_framer.sv
module dtx_framer
  import dtx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int QUEUE_W = 24,
  parameter int CHUNK_W = DATA_W + 3,
  parameter int CW      = $clog2(QUEUE_W + 1),
  parameter int LW      = $clog2(CHUNK_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_set,
  input  logic [1:0]        cfg_rate,
  input  logic              cfg_byte_mode,
  input  logic              cfg_frame_en,
  input  logic              cfg_parity_en,
  input  logic              cfg_msb_first,
  input  logic              frame_tick,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic [CW-1:0]     q_cnt,
  output logic              fifo_pop,
  output logic              ld_en,
  output logic [CHUNK_W-1:0] ld_bits,
  output logic [LW-1:0]     ld_len,
  output logic              armed
);
  logic              in_msg, par_acc;
  logic [CW-1:0]     nb;
  logic [DATA_W-1:0] d_ord;
  logic              d_par, msg_mode, slot_free, take, finish;

  assign nb        = CW'(frame_bits(cfg_rate, DATA_W));
  assign msg_mode  = !cfg_byte_mode;
  assign d_par     = ^fifo_data;
  assign slot_free = !frame_tick && (q_cnt <= CW'(QUEUE_W - CHUNK_W));
  assign take      = armed && !fifo_empty && slot_free;
  assign finish    = msg_mode && in_msg && fifo_empty && slot_free && (q_cnt < nb);
  assign fifo_pop  = take;
  assign ld_en     = take || finish;

  always_comb begin
    for (int k = 0; k < DATA_W; k++)
      d_ord[k] = cfg_msb_first ? fifo_data[DATA_W-1-k] : fifo_data[k];
  end

  // chunk bit 0 goes out first; unused chunk bits stay at stop level
  always_comb begin
    ld_bits = '1;
    ld_len  = '0;
    if (take) begin
      if (msg_mode) begin
        if (!in_msg) begin
          ld_bits[0]        = 1'b0;
          ld_bits[DATA_W:1] = d_ord;
          ld_len            = LW'(DATA_W + 1);
        end else begin
          ld_bits[DATA_W-1:0] = d_ord;
          ld_len              = LW'(DATA_W);
        end
      end else if (cfg_frame_en) begin
        ld_bits[0]        = 1'b0;
        ld_bits[DATA_W:1] = d_ord;
        if (cfg_parity_en) begin
          ld_bits[DATA_W+1] = d_par;
          ld_len            = LW'(DATA_W + 3);
        end else begin
          ld_len            = LW'(DATA_W + 2);
        end
      end else begin
        ld_bits[DATA_W-1:0] = d_ord;
        ld_len              = LW'(DATA_W);
      end
    end else if (finish) begin
      if (cfg_parity_en) begin
        ld_bits[0] = par_acc;
        ld_len     = LW'(2);
      end else begin
        ld_len     = LW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      in_msg  <= 1'b0;
      par_acc <= 1'b0;
    end else begin
      if (start_set)   armed <= 1'b1;
      else if (finish) armed <= 1'b0;
      if (take && msg_mode) begin
        in_msg  <= 1'b1;
        par_acc <= in_msg ? (par_acc ^ d_par) : d_par;
      end else if (finish) begin
        in_msg  <= 1'b0;
      end
    end
  end

  // R6: arming only drops at the end of a framed message
  assert_disarm_msg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $past(msg_mode));
  // R11: the environment keeps ticks apart
  assert_tick_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> !frame_tick);
endmodule

// File: rtl/dtx_shifter.sv
module dtx_shifter
  import dtx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int QUEUE_W = 24,
  parameter int CHUNK_W = DATA_W + 3,
  parameter int CW      = $clog2(QUEUE_W + 1),
  parameter int LW      = $clog2(CHUNK_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_tick,
  input  logic [1:0]         cfg_rate,
  input  logic               ld_en,
  input  logic [CHUNK_W-1:0] ld_bits,
  input  logic [LW-1:0]      ld_len,
  output logic [CW-1:0]      q_cnt,
  output logic [DATA_W-1:0]  slot_out
);
  localparam logic [QUEUE_W-1:0] ONES = '1;

  logic [QUEUE_W-1:0] queue, lenmask, shifted, merged;
  logic [CW-1:0]      nb;
  logic [DATA_W-1:0]  slot_nx;

  assign nb      = CW'(frame_bits(cfg_rate, DATA_W));
  assign shifted = (queue >> nb) | ~(ONES >> nb);
  assign lenmask = ~(ONES << ld_len);
  assign merged  = (queue & ~(lenmask << q_cnt))
                 | ((QUEUE_W'(ld_bits) & lenmask) << q_cnt);

  always_comb begin
    for (int j = 0; j < DATA_W; j++)
      slot_nx[j] = (CW'(j) < nb) ? queue[j] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      queue    <= '1;
      q_cnt    <= '0;
      slot_out <= '1;
    end else if (frame_tick) begin
      slot_out <= slot_nx;
      queue    <= shifted;
      q_cnt    <= (q_cnt > nb) ? q_cnt - nb : '0;
    end else if (ld_en) begin
      queue    <= merged;
      q_cnt    <= q_cnt + CW'(ld_len);
    end
  end

  // R3: at one bit per frame every upper slot bit is stop level
  assert_pad_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && cfg_rate == 2'd0) |=> (slot_out[DATA_W-1:1] == '1));
  // R11: the slot only moves on a tick
  assert_slot_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(slot_out));
  // R1: queue occupancy within its storage
  assert_queue_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(QUEUE_W));
endmodule

// File: rtl/dch_slot_tx.sv
module dch_slot_tx
  import dtx_pkg::*;
#(
  parameter int DATA_W     = DTX_DATA_W,
  parameter int FIFO_DEPTH = DTX_FIFO_DEPTH,
  parameter int QUEUE_W    = DTX_QUEUE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start_set,
  output logic              tx_armed,
  input  logic              ovf_clr,
  output logic              ovf,
  input  logic [1:0]        cfg_rate,
  input  logic              cfg_byte_mode,
  input  logic              cfg_frame_en,
  input  logic              cfg_parity_en,
  input  logic              cfg_msb_first,
  input  logic              frame_tick,
  output logic [DATA_W-1:0] slot_out
);
  localparam int CHUNK_W = DATA_W + 3;
  localparam int CW      = $clog2(QUEUE_W + 1);
  localparam int LW      = $clog2(CHUNK_W + 1);

  logic              f_empty, f_pop, ld_en;
  logic [DATA_W-1:0] f_data;
  logic [CW-1:0]     q_cnt;
  logic [CHUNK_W-1:0] ld_bits;
  logic [LW-1:0]     ld_len;

  dtx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_pop(f_pop), .rd_data(f_data), .empty(f_empty),
    .ovf_clr(ovf_clr), .ovf(ovf)
  );

  dtx_framer #(.DATA_W(DATA_W), .QUEUE_W(QUEUE_W), .CHUNK_W(CHUNK_W),
               .CW(CW), .LW(LW)) u_framer (
    .clk(clk), .rst_n(rst_n), .start_set(start_set), .cfg_rate(cfg_rate),
    .cfg_byte_mode(cfg_byte_mode), .cfg_frame_en(cfg_frame_en),
    .cfg_parity_en(cfg_parity_en), .cfg_msb_first(cfg_msb_first),
    .frame_tick(frame_tick), .fifo_empty(f_empty), .fifo_data(f_data),
    .q_cnt(q_cnt), .fifo_pop(f_pop), .ld_en(ld_en), .ld_bits(ld_bits),
    .ld_len(ld_len), .armed(tx_armed)
  );

  dtx_shifter #(.DATA_W(DATA_W), .QUEUE_W(QUEUE_W), .CHUNK_W(CHUNK_W),
                .CW(CW), .LW(LW)) u_shifter (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .cfg_rate(cfg_rate),
    .ld_en(ld_en), .ld_bits(ld_bits), .ld_len(ld_len), .q_cnt(q_cnt),
    .slot_out(slot_out)
  );
endmodule

// File: tb/dch_slot_tx_bench.sv
module dch_slot_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, start_set = 1'b0, ovf_clr = 1'b0, frame_tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_rate = '0;
  logic       cfg_byte_mode = 1'b0, cfg_frame_en = 1'b0, cfg_parity_en = 1'b0, cfg_msb_first = 1'b0;
  logic       wr_ready, tx_armed, ovf;
  logic [7:0] slot_out;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dch_slot_tx u_dch_slot_tx (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .start_set(start_set), .tx_armed(tx_armed),
    .ovf_clr(ovf_clr), .ovf(ovf), .cfg_rate(cfg_rate),
    .cfg_byte_mode(cfg_byte_mode), .cfg_frame_en(cfg_frame_en),
    .cfg_parity_en(cfg_parity_en), .cfg_msb_first(cfg_msb_first),
    .frame_tick(frame_tick), .slot_out(slot_out)
  );

  // {byte_mode, frame_en, parity_en, msb_first, rate[1:0], nbytes[1:0], b0, b1, b2, len[5:0]}
  localparam int NV = 8;
  localparam logic [37:0] VECS [NV] = '{
    {1'b0,1'b0,1'b0,1'b0,2'd2,2'd1,8'hA5,8'h00,8'h00,6'd10},
    {1'b0,1'b0,1'b1,1'b0,2'd1,2'd2,8'h3C,8'h81,8'h00,6'd19},
    {1'b0,1'b1,1'b1,1'b1,2'd0,2'd1,8'h07,8'h00,8'h00,6'd11},
    {1'b1,1'b0,1'b1,1'b0,2'd2,2'd2,8'h5A,8'hC3,8'h00,6'd16},
    {1'b1,1'b1,1'b0,1'b1,2'd1,2'd1,8'h96,8'h00,8'h00,6'd10},
    {1'b1,1'b1,1'b1,1'b0,2'd2,2'd2,8'hF0,8'h01,8'h00,6'd22},
    {1'b1,1'b1,1'b1,1'b1,2'd3,2'd3,8'h12,8'h34,8'hFE,6'd33},
    {1'b0,1'b1,1'b0,1'b1,2'd0,2'd3,8'h80,8'h01,8'hFF,6'd26}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
  endtask

  task automatic gap();
    repeat (2) @(negedge clk);
  endtask

  task automatic arm();
    @(negedge clk) start_set = 1'b1;
    @(negedge clk) start_set = 1'b0;
  endtask

  function automatic int rate_bits(logic [1:0] r);
    return (r == 2'd0) ? 1 : (r == 2'd1) ? 2 : 8;
  endfunction

  // serial stream model from the framing requirements; bit 0 is sent first
  function automatic void model(input logic [37:0] v, output logic [63:0] s, output int n);
    logic [7:0] bt;
    logic pacc;
    int nby;
    s = '1; n = 0; pacc = 1'b0;
    nby = int'(v[31:30]);
    for (int b = 0; b < nby; b++) begin
      bt = (b == 0) ? v[29:22] : (b == 1) ? v[21:14] : v[13:6];
      if (!v[37]) begin
        if (b == 0) begin s[n] = 1'b0; n++; end
        pacc ^= ^bt;
      end else if (v[36]) begin
        s[n] = 1'b0; n++;
      end
      for (int k = 0; k < 8; k++) begin
        s[n] = v[34] ? bt[7-k] : bt[k]; n++;
      end
      if (v[37] && v[36]) begin
        if (v[35]) begin s[n] = ^bt; n++; end
        s[n] = 1'b1; n++;
      end
    end
    if (!v[37]) begin
      if (v[35]) begin s[n] = pacc; n++; end
      s[n] = 1'b1; n++;
    end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] strm;
    logic [7:0]  exp_slot;
    int          len, nb, nt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(slot_out == 8'hFF, "R10 reset slot", 32'(slot_out), 32'hFF);
    chk(tx_armed == 1'b0 && ovf == 1'b0 && wr_ready == 1'b1, "R10 reset flags",
        {29'd0, tx_armed, ovf, wr_ready}, 32'h1);

    // table walk: R3..R9, R11
    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VECS[i];
      cfg_byte_mode = v[37]; cfg_frame_en = v[36]; cfg_parity_en = v[35];
      cfg_msb_first = v[34]; cfg_rate = v[33:32];
      model(v, strm, len);
      chk(len == int'(v[5:0]), "R4 R8 frame length", 32'(len), 32'(v[5:0]));
      arm();
      for (int b = 0; b < int'(v[31:30]); b++) begin
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = (b == 0) ? v[29:22] : (b == 1) ? v[21:14] : v[13:6];
      end
      @(negedge clk) wr_valid = 1'b0;
      repeat (4) @(negedge clk);
      nb = rate_bits(v[33:32]);
      nt = (int'(v[5:0]) + nb - 1) / nb + 1;
      for (int t = 0; t < nt; t++) begin
        tick();
        for (int j = 0; j < 8; j++)
          exp_slot[j] = (j < nb && t*nb + j < len) ? strm[t*nb + j] : 1'b1;
        // R3 R4 R5 R7 R8 R9 R10 R11: slot content per frame
        chk(slot_out == exp_slot, $sformatf("R3 R9 R10 vec%0d frame%0d", i, t),
            32'(slot_out), 32'(exp_slot));
        gap();
      end
      // R6: message framing disarms at the end; R8: byte framing stays armed
      chk(tx_armed == v[37], $sformatf("R6 R8 armed after vec%0d", i),
          32'(tx_armed), 32'(v[37]));
    end

    // R1 / R2: fill without arming, overflow, then drain
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    cfg_byte_mode = 1'b1; cfg_frame_en = 1'b0; cfg_parity_en = 1'b1;
    cfg_msb_first = 1'b0; cfg_rate = 2'd2;
    for (int b = 0; b < 32; b++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = 8'(b * 7 + 3);
    end
    @(negedge clk) wr_valid = 1'b0;
    chk(wr_ready == 1'b0, "R1 ready low when full", 32'(wr_ready), 32'h0);
    chk(ovf == 1'b0, "R1 no flag before drop", 32'(ovf), 32'h0);
    wr_valid = 1'b1; wr_data = 8'hAA;
    @(negedge clk) wr_valid = 1'b0;
    chk(ovf == 1'b1, "R1 flag on drop", 32'(ovf), 32'h1);
    repeat (3) @(negedge clk);
    tick();
    chk(slot_out == 8'hFF, "R2 idle before arm", 32'(slot_out), 32'hFF);
    gap();
    chk(ovf == 1'b1, "R1 flag sticky", 32'(ovf), 32'h1);
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    chk(ovf == 1'b0, "R1 flag cleared", 32'(ovf), 32'h0);
    arm();
    repeat (4) @(negedge clk);
    for (int b = 0; b < 32; b++) begin
      tick();
      // R1 R7: queued bytes intact, no framing or parity
      chk(slot_out == 8'(b * 7 + 3), $sformatf("R1 R7 drain byte%0d", b),
          32'(slot_out), 32'(8'(b * 7 + 3)));
      gap();
    end
    tick();
    chk(slot_out == 8'hFF, "R1 dropped byte absent", 32'(slot_out), 32'hFF);
    chk(wr_ready == 1'b1, "R1 ready after drain", 32'(wr_ready), 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule